// File: doc/BRIEF.md
# Zero-Penalty Branch Fetch Stage

This block is the instruction fetch stage of a five-stage RISC pipeline. It fetches one instruction per cycle from an instruction memory with a combinational read port and hands it to decode together with its PC and a valid flag. Decode resolves branches in the same cycle it holds them and reports the outcome back through `dec_is_branch`, `dec_taken` and `dec_target`.

A plain fetch stage loses one cycle on each taken branch, because the target address is only known in decode. This stage keeps a direct-mapped target buffer. Each entry is keyed by the address of a branch and stores three things: the instruction at the branch target, the target PC, and the target PC plus 4. Every cycle the buffer is read twice. One lookup uses the fetch PC. The other uses the target PC held in a side register that travels alongside the instruction in decode. When decode reports a taken branch that the side register predicted correctly, the next decode slot takes the target instruction straight from the buffer. Fetch then continues at target+4, so no cycle is lost. Chains of taken branches are followed through the second lookup.

Entries are installed through a write port. The write lands one cycle after the request. A miss, a tag mismatch or a stale target all make the stage redirect to the resolved target and insert one bubble.

Top module: `fetch_tib_top`

## Requirements
- R1: While `rst_n` is low, `dec_valid` is 0 and `imem_addr` equals the reset PC (0). Reset invalidates every buffer entry, so a taken branch after reset always takes the one-bubble path.
- R2: With no taken branch in decode and `pc_stall` low, `imem_addr` rises by 4 each cycle. Decode receives `imem_rdata` and its address one cycle after that address was on `imem_addr`.
- R3: A buffer write request (`wr_req` with `wr_pc`, `wr_instr`, `wr_target`) is registered and written to the entry on the following edge. The entry is indexed by PC bits [5:2] and tagged by PC bits [31:6]. A lookup hits only on a valid entry whose tag matches.
- R4: A taken branch in decode whose buffer lookup hit with a stored target equal to `dec_target` gives, one cycle later, `dec_valid`=1, `dec_pc`=target, `dec_instr`=the stored target instruction, and `imem_addr`=target+4.
- R5: In the cycle after R4, decode receives the memory instruction at target+4, so the taken branch inserts no bubble.
- R6: A taken branch whose lookup missed (no valid entry, or a tag mismatch) gives one cycle of `dec_valid`=0 with `imem_addr`=`dec_target`. In the next cycle decode holds the memory instruction at the target.
- R7: A lookup that hits but whose stored target differs from `dec_target` is handled as a miss (R6). Fast and slow redirects never occur together.
- R8: When the target instruction delivered by R4 is itself a taken branch with a matching entry, the next decode slot again comes from the buffer with no bubble.
- R9: A branch reported not taken, or `dec_taken` high while `dec_is_branch` is low, leaves the sequential flow of R2 unchanged.
- R10: While `pc_stall` is high, `imem_addr`, `dec_valid`, `dec_pc` and `dec_instr` hold their values, even if a taken branch is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_stall | input | 1 | Freeze all fetch state |
| imem_addr | output | 32 | Instruction memory read address (the PC) |
| imem_rdata | input | 32 | Instruction at `imem_addr`, same cycle |
| dec_is_branch | input | 1 | Instruction in decode is a branch |
| dec_taken | input | 1 | That branch is taken |
| dec_target | input | 32 | Resolved branch target |
| wr_req | input | 1 | Install a buffer entry |
| wr_pc | input | 32 | Address of the branch being installed |
| wr_instr | input | 32 | Instruction at the branch target |
| wr_target | input | 32 | Branch target PC |
| dec_valid | output | 1 | Decode slot holds a real instruction |
| dec_instr | output | 32 | Instruction for decode |
| dec_pc | output | 32 | PC of `dec_instr` |

## Verification
The bench targets the timing of the two-cycle redirect. One case is a hit whose instruction must come from the buffer: a design that read memory there would show the memory word instead of the marker value. Another is the fetch address after a hit, which must be target+4: a design that got this wrong would fetch the target twice. Chained taken branches exercise the second lookup. A design that indexed both lookups by the PC would bubble or deliver the wrong target there. Tag mismatches, stale targets and a cleared buffer after reset must all produce exactly one bubble and then the target. The stall case holds a taken branch in decode across frozen cycles and checks that nothing advances until release.

// File: rtl/fetch_tib_pkg.sv
package fetch_tib_pkg;
  localparam int XLEN  = 32;
  localparam int IDX_W = 4;
  localparam int OFS_W = 2;
  localparam int TAG_W = XLEN - IDX_W - OFS_W;
  localparam int DEPTH = 1 << IDX_W;

  // One buffer read result: hit flag plus the three stored fields.
  typedef struct packed {
    logic            hit;
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] tpc;
    logic [XLEN-1:0] tpc4;
  } look_t;

  function automatic logic [XLEN-1:0] step_pc(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

  function automatic logic [IDX_W-1:0] index_of(input logic [XLEN-1:0] pc);
    return pc[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [XLEN-1:0] pc);
    return pc[XLEN-1 -: TAG_W];
  endfunction
endpackage

// File: rtl/fetch_tib_buf.sv
module fetch_tib_buf
  import fetch_tib_pkg::*;
#(
  parameter int N_RD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  logic [XLEN-1:0] wr_pc,
  input  logic [XLEN-1:0] wr_instr,
  input  logic [XLEN-1:0] wr_target,
  input  logic [XLEN-1:0] rd_pc  [N_RD],
  output look_t           rd_res [N_RD]
);
  // Write request is delayed by one cycle before it touches storage.
  logic            wen_q;
  logic [XLEN-1:0] wpc_q, winstr_q, wtgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) wen_q <= 1'b0;
    else        wen_q <= wr_req;
  end

  always_ff @(posedge clk) begin
    if (wr_req) begin
      wpc_q    <= wr_pc;
      winstr_q <= wr_instr;
      wtgt_q   <= wr_target;
    end
  end

  logic             ent_v     [DEPTH];
  logic [TAG_W-1:0] ent_tag   [DEPTH];
  logic [XLEN-1:0]  ent_instr [DEPTH];
  logic [XLEN-1:0]  ent_tpc   [DEPTH];
  logic [XLEN-1:0]  ent_tpc4  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_v[i] <= 1'b0;
    end else if (wen_q) begin
      ent_v[index_of(wpc_q)] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wen_q) begin
      ent_tag[index_of(wpc_q)]   <= tag_of(wpc_q);
      ent_instr[index_of(wpc_q)] <= winstr_q;
      ent_tpc[index_of(wpc_q)]   <= wtgt_q;
      ent_tpc4[index_of(wpc_q)]  <= step_pc(wtgt_q);
    end
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    logic [IDX_W-1:0] idx;
    assign idx = index_of(rd_pc[g]);
    always_comb begin
      rd_res[g].hit   = ent_v[idx] && (ent_tag[idx] == tag_of(rd_pc[g]));
      rd_res[g].instr = ent_instr[idx];
      rd_res[g].tpc   = ent_tpc[idx];
      rd_res[g].tpc4  = ent_tpc4[idx];
    end
  end
endmodule

// File: rtl/fetch_tib_steer.sv
module fetch_tib_steer
  import fetch_tib_pkg::*;
(
  input  logic            dec_valid,
  input  logic            dec_is_branch,
  input  logic            dec_taken,
  input  logic [XLEN-1:0] dec_target,
  input  look_t           held,
  input  logic [XLEN-1:0] pc,
  output logic            take_fast,
  output logic            take_slow,
  output logic [XLEN-1:0] next_pc
);
  logic resolved_taken;
  logic target_ok;

  assign resolved_taken = dec_valid && dec_is_branch && dec_taken;
  assign target_ok      = held.hit && (held.tpc == dec_target);
  assign take_fast      = resolved_taken && target_ok;
  assign take_slow      = resolved_taken && !target_ok;

  always_comb begin
    if (take_fast)      next_pc = held.tpc4;
    else if (take_slow) next_pc = dec_target;
    else                next_pc = step_pc(pc);
  end
endmodule

// File: rtl/fetch_tib_top.sv
module fetch_tib_top
  import fetch_tib_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_stall,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  input  logic            dec_is_branch,
  input  logic            dec_taken,
  input  logic [XLEN-1:0] dec_target,
  input  logic            wr_req,
  input  logic [XLEN-1:0] wr_pc,
  input  logic [XLEN-1:0] wr_instr,
  input  logic [XLEN-1:0] wr_target,
  output logic            dec_valid,
  output logic [XLEN-1:0] dec_instr,
  output logic [XLEN-1:0] dec_pc
);
  localparam int N_RD = 2;

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] f1_instr, f1_pc;
  logic            f1_v;
  look_t           held_q;
  logic [XLEN-1:0] t2_instr, t2_pc;
  logic            use_t2;

  logic [XLEN-1:0] rd_pc  [N_RD];
  look_t           rd_res [N_RD];
  logic            take_fast, take_slow;
  logic [XLEN-1:0] next_pc;

  assign rd_pc[0] = pc_q;
  assign rd_pc[1] = held_q.tpc;

  fetch_tib_buf #(.N_RD(N_RD)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .wr_pc     (wr_pc),
    .wr_instr  (wr_instr),
    .wr_target (wr_target),
    .rd_pc     (rd_pc),
    .rd_res    (rd_res)
  );

  fetch_tib_steer u_steer (
    .dec_valid     (dec_valid),
    .dec_is_branch (dec_is_branch),
    .dec_taken     (dec_taken),
    .dec_target    (dec_target),
    .held          (held_q),
    .pc            (pc_q),
    .take_fast     (take_fast),
    .take_slow     (take_slow),
    .next_pc       (next_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      f1_instr <= '0;
      f1_pc    <= '0;
      f1_v     <= 1'b0;
      held_q   <= '0;
      t2_instr <= '0;
      t2_pc    <= '0;
      use_t2   <= 1'b0;
    end else if (!pc_stall) begin
      pc_q     <= next_pc;
      f1_instr <= imem_rdata;
      f1_pc    <= pc_q;
      f1_v     <= !(take_fast || take_slow);
      held_q   <= take_fast ? rd_res[1] : rd_res[0];
      t2_instr <= held_q.instr;
      t2_pc    <= held_q.tpc;
      use_t2   <= take_fast;
    end
  end

  assign imem_addr = pc_q;
  assign dec_valid = use_t2 || f1_v;
  assign dec_instr = use_t2 ? t2_instr : f1_instr;
  assign dec_pc    = use_t2 ? t2_pc : f1_pc;
endmodule

// File: rtl/fetch_tib_chk.sv
module fetch_tib_chk
  import fetch_tib_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            pc_stall,
  input logic [XLEN-1:0] imem_addr,
  input logic            dec_valid,
  input logic [XLEN-1:0] dec_pc,
  input logic [XLEN-1:0] dec_instr,
  input logic [XLEN-1:0] dec_target,
  input logic            take_fast,
  input logic            take_slow
);
  p_seq_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_stall && !take_fast && !take_slow) |=> imem_addr == $past(imem_addr) + XLEN'(4));

  p_fast_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_fast && !pc_stall) |=>
      (dec_valid && dec_pc == $past(dec_target) && imem_addr == $past(dec_target) + XLEN'(4)));

  p_slow_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_slow && !pc_stall) |=> (!dec_valid && imem_addr == $past(dec_target)));

  p_one_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_fast && take_slow));

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_stall |=> ($stable(imem_addr) && $stable(dec_valid) && $stable(dec_pc) && $stable(dec_instr)));
endmodule

bind fetch_tib_top fetch_tib_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc_stall   (pc_stall),
  .imem_addr  (imem_addr),
  .dec_valid  (dec_valid),
  .dec_pc     (dec_pc),
  .dec_instr  (dec_instr),
  .dec_target (dec_target),
  .take_fast  (take_fast),
  .take_slow  (take_slow)
);

// File: tb/fetch_tib_top_bench.sv
module fetch_tib_top_bench;
  logic        clk = 1'b0;
  logic        rst_n, pc_stall;
  logic [31:0] imem_addr, imem_rdata;
  logic        dec_is_branch, dec_taken;
  logic [31:0] dec_target;
  logic        wr_req;
  logic [31:0] wr_pc, wr_instr, wr_target;
  logic        dec_valid;
  logic [31:0] dec_instr, dec_pc;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fetch_tib_top u_fetch_tib_top (
    .clk(clk), .rst_n(rst_n), .pc_stall(pc_stall),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dec_is_branch(dec_is_branch), .dec_taken(dec_taken), .dec_target(dec_target),
    .wr_req(wr_req), .wr_pc(wr_pc), .wr_instr(wr_instr), .wr_target(wr_target),
    .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_pc(dec_pc)
  );

  function automatic logic [31:0] memw(input logic [31:0] a);
    return {8'hC3, a[23:0]};
  endfunction
  function automatic logic [31:0] mark(input logic [31:0] t);
    return 32'hB000_0000 | t;
  endfunction

  assign imem_rdata = memw(imem_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic br, input logic tk, input logic [31:0] tgt);
    dec_is_branch = br; dec_taken = tk; dec_target = tgt;
    @(negedge clk);
  endtask

  task automatic idle();
    tick(1'b0, 1'b0, 32'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pc_stall = 1'b0; wr_req = 1'b0;
    wr_pc = '0; wr_instr = '0; wr_target = '0;
    repeat (3) idle();
    chk("R1 reset dec_valid", {31'b0, dec_valid}, 32'h0);
    chk("R1 reset imem_addr", imem_addr, 32'h0);
    rst_n = 1'b1;
    idle();
  endtask

  task automatic buf_write(input logic [31:0] bpc, input logic [31:0] tgt);
    wr_pc = bpc; wr_instr = mark(tgt); wr_target = tgt; wr_req = 1'b1;
    idle();
    wr_req = 1'b0;
    idle();
  endtask

  // Redirect by a taken branch that misses; returns with decode holding a.
  task automatic go_to(input logic [31:0] a);
    while (!dec_valid) idle();
    tick(1'b1, 1'b1, a);
    idle();
  endtask

  task automatic t_reset_seq();
    do_reset();
    chk("R2 first imem_addr", imem_addr, 32'h4);
    chk("R2 first dec_valid", {31'b0, dec_valid}, 32'h1);
    chk("R2 first dec_pc", dec_pc, 32'h0);
    chk("R2 first dec_instr", dec_instr, memw(32'h0));
    idle();
    chk("R2 next imem_addr", imem_addr, 32'h8);
    chk("R2 next dec_pc", dec_pc, 32'h4);
  endtask

  task automatic t_fast();
    go_to(32'h104);
    chk("R6 redirect dec_pc", dec_pc, 32'h104);
    tick(1'b1, 1'b1, 32'h208);
    chk("R4 fast dec_valid", {31'b0, dec_valid}, 32'h1);
    chk("R4 fast dec_pc", dec_pc, 32'h208);
    chk("R4 fast dec_instr", dec_instr, mark(32'h208));
    chk("R4 fast imem_addr", imem_addr, 32'h20C);
    idle();
    chk("R5 follow dec_pc", dec_pc, 32'h20C);
    chk("R5 follow dec_instr", dec_instr, memw(32'h20C));
    chk("R5 follow imem_addr", imem_addr, 32'h210);
  endtask

  task automatic t_chain();
    go_to(32'h104);
    tick(1'b1, 1'b1, 32'h208);
    tick(1'b1, 1'b1, 32'h30C);
    chk("R8 chain dec_valid", {31'b0, dec_valid}, 32'h1);
    chk("R8 chain dec_pc", dec_pc, 32'h30C);
    chk("R8 chain dec_instr", dec_instr, mark(32'h30C));
    chk("R8 chain imem_addr", imem_addr, 32'h310);
    idle();
    chk("R8 chain follow dec_pc", dec_pc, 32'h310);
  endtask

  task automatic t_tag_miss();
    go_to(32'h144);
    tick(1'b1, 1'b1, 32'h208);
    chk("R3 tag mismatch bubble", {31'b0, dec_valid}, 32'h0);
    chk("R6 miss imem_addr", imem_addr, 32'h208);
    idle();
    chk("R6 miss dec_pc", dec_pc, 32'h208);
    chk("R6 miss dec_instr from memory", dec_instr, memw(32'h208));
  endtask

  task automatic t_stale();
    go_to(32'h104);
    tick(1'b1, 1'b1, 32'h400);
    chk("R7 stale bubble", {31'b0, dec_valid}, 32'h0);
    chk("R7 stale imem_addr", imem_addr, 32'h400);
    idle();
    chk("R7 stale dec_pc", dec_pc, 32'h400);
  endtask

  task automatic t_not_taken();
    go_to(32'h104);
    tick(1'b1, 1'b0, 32'h208);
    chk("R9 not taken dec_pc", dec_pc, 32'h108);
    chk("R9 not taken imem_addr", imem_addr, 32'h10C);
    go_to(32'h104);
    tick(1'b0, 1'b1, 32'h208);
    chk("R9 non-branch dec_pc", dec_pc, 32'h108);
    chk("R9 non-branch dec_instr", dec_instr, memw(32'h108));
  endtask

  task automatic t_stall();
    go_to(32'h104);
    pc_stall = 1'b1;
    tick(1'b1, 1'b1, 32'h208);
    chk("R10 stall dec_pc", dec_pc, 32'h104);
    chk("R10 stall imem_addr", imem_addr, 32'h108);
    tick(1'b1, 1'b1, 32'h208);
    chk("R10 stall2 dec_pc", dec_pc, 32'h104);
    chk("R10 stall2 dec_valid", {31'b0, dec_valid}, 32'h1);
    pc_stall = 1'b0;
    tick(1'b1, 1'b1, 32'h208);
    chk("R10 release dec_pc", dec_pc, 32'h208);
    chk("R10 release dec_instr", dec_instr, mark(32'h208));
  endtask

  task automatic t_reset_clear();
    do_reset();
    go_to(32'h104);
    tick(1'b1, 1'b1, 32'h208);
    chk("R1 cleared buffer bubble", {31'b0, dec_valid}, 32'h0);
    chk("R1 cleared buffer imem_addr", imem_addr, 32'h208);
  endtask

  initial begin
    t_reset_seq();
    buf_write(32'h104, 32'h208);   // R3 entry install
    buf_write(32'h208, 32'h30C);
    t_fast();
    t_chain();
    t_tag_miss();
    t_stale();
    t_not_taken();
    t_stall();
    t_reset_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule